// File: doc/BRIEF.md
# Triggered Three-Frame Raw Capture Controller

This block sits behind a pixel digitiser during full, non-thresholded readout. Raw pixels arrive on a valid/ready stream in scan order. The block writes each frame into one buffer of a ring of frame buffers, and every frame starts at pixel 0. When a trigger comes in, the block notes which buffer holds the frame now being scanned. It keeps recording until the frame after that one is complete, and then it freezes.

After the freeze, the block stops taking pixels. It presents three whole raw frames on a valid/ready read port, in this order:
- the frame before the trigger frame,
- the trigger frame itself,
- the frame after the trigger frame.

Within each frame the pixel addresses rise from 0. Once the last pixel has been read, the block drives a sensor reset for a fixed number of cycles. It then arms again and scans a fresh frame from pixel 0.

Back-pressure works as follows. On the pixel input, a pixel is taken only in a cycle where both `pix_valid` and `pix_ready` are high. `pix_ready` is low for the whole time the block is frozen, reading out or resetting, and the upstream side must hold its data during that time. On the read port, the block keeps `rd_valid`, `rd_data`, `rd_frame`, `rd_addr` and `rd_last` steady for as long as `rd_ready` is low. A pixel leaves the block only in a cycle where both `rd_valid` and `rd_ready` are high.

Top module: `mfc_capture`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `sens_rst` are low and `pix_ready` is high.
- R2: While recording, `pix_ready` stays high and every accepted pixel is stored at the next address of the current frame. The address wraps to 0 after pixel FRAME_PIX-1, and the next buffer of the ring is then used.
- R3: A trigger is taken in a cycle where `trig` is high, `busy` is low, recording is active and at least one whole frame has been stored since arming. The trigger frame is the frame that the pixel accepted in that cycle (or the next pixel accepted) belongs to.
- R4: A trigger is ignored, with no effect on `busy` or on the frames read out, in three cases: while `busy` is high, during the sensor reset, and before the first whole frame after arming is stored.
- R5: `busy` rises in the cycle after a trigger is taken. It falls in the cycle after the final read handshake.
- R6: `pix_ready` falls in the cycle after the last pixel of the frame after the trigger frame is accepted. Counting the trigger-cycle pixel, exactly 2*FRAME_PIX - P pixels are accepted from the trigger onward, where P is the trigger pixel's address.
- R7: The read port delivers the three frames with `rd_frame` = 0 (previous), 1 (trigger) and 2 (next). Within each frame `rd_addr` rises from 0 to FRAME_PIX-1. `rd_last` is high only on pixel FRAME_PIX-1 of frame 2.
- R8: While `rd_valid` is high and `rd_ready` is low, the read outputs hold their values.
- R9: Every value read out equals the raw pixel value that was accepted at that frame and address.
- R10: `sens_rst` is high for exactly RST_CYCLES cycles, starting in the cycle after the final read handshake. After that, `pix_ready` returns high and recording restarts at pixel 0 of a fresh frame, and a new whole frame is needed before a trigger is taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | A raw pixel is offered |
| pix_ready | output | 1 | The block takes the offered pixel (recording active) |
| pix_data | input | PIX_W (8) | Raw pixel value |
| trig | input | 1 | Trigger request, sampled each cycle |
| busy | output | 1 | An event is pending or being read out |
| rd_valid | output | 1 | A captured pixel is presented |
| rd_ready | input | 1 | The host takes the presented pixel |
| rd_data | output | PIX_W (8) | Captured raw pixel value |
| rd_frame | output | 2 | Frame position in the event: 0 previous, 1 trigger, 2 next |
| rd_addr | output | ADDR_W (4) | Pixel address within the frame |
| rd_last | output | 1 | Final pixel of the event |
| sens_rst | output | 1 | Sensor reset request |

## Verification
Results fall due at these times:
- `busy` one cycle after the edge that takes the trigger.
- `pix_ready` falls one cycle after the edge that accepts the closing pixel of the next frame.
- `busy` falls and `sens_rst` rises together, one cycle after the final read handshake edge.
- `sens_rst` stays high for RST_CYCLES cycles, after which `pix_ready` returns.
- Read data is presented in the same cycle as `rd_valid`, straight from the frame store.

The bench drives inputs on the falling edge and samples every output on the next falling edge, half a period after the edge that settled it. It counts the accepted pixels between the trigger and the freeze, and counts the cycles `sens_rst` stays high, rather than waiting for an event to occur.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic [1:0] {
    MODE_REC  = 2'd0,
    MODE_READ = 2'd1,
    MODE_RST  = 2'd2
  } mode_e;
endpackage

// File: rtl/mfc_store.sv
module mfc_store #(
  parameter int PIX_W  = 8,
  parameter int NBUF   = 4,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(NBUF)-1:0]  wr_buf,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [PIX_W-1:0]         wr_data,
  input  logic [$clog2(NBUF)-1:0]  rd_buf,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [PIX_W-1:0]         rd_data
);
  localparam int BUF_W     = $clog2(NBUF);
  localparam int FRAME_PIX = 1 << ADDR_W;

  logic [PIX_W-1:0] bank_rd [NBUF];

  // one bank per ring slot; only the addressed slot takes the write
  for (genvar b = 0; b < NBUF; b++) begin : g_bank
    logic [PIX_W-1:0] cells [FRAME_PIX];
    always_ff @(posedge clk) begin
      if (wr_en && wr_buf == BUF_W'(b)) cells[wr_addr] <= wr_data;
    end
    assign bank_rd[b] = cells[rd_addr];
  end

  assign rd_data = bank_rd[rd_buf];
endmodule

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
  import mfc_pkg::*;
#(
  parameter int NBUF       = 4,
  parameter int ADDR_W     = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pix_valid,
  input  logic                     trig,
  input  logic                     rd_done,
  output logic                     pix_ready,
  output logic                     wr_en,
  output logic [$clog2(NBUF)-1:0]  wr_buf,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic                     busy,
  output logic                     sens_rst,
  output logic                     reading,
  output logic [$clog2(NBUF)-1:0]  trig_buf
);
  localparam int BUF_W  = $clog2(NBUF);
  localparam int RCNT_W = $clog2(RST_CYCLES + 1);

  mode_e              mode_q;
  logic [BUF_W-1:0]   wbuf_q, tbuf_q;
  logic [ADDR_W-1:0]  pcnt_q;
  logic [RCNT_W-1:0]  rcnt_q;
  logic               primed_q, busy_q;
  logic               frame_end, trig_take, next_done;

  assign pix_ready = (mode_q == MODE_REC);
  assign wr_en     = pix_ready && pix_valid;
  assign frame_end = wr_en && (pcnt_q == '1);
  assign trig_take = trig && !busy_q && primed_q && (mode_q == MODE_REC);
  // the frame after the trigger frame is the one just closing
  assign next_done = busy_q && (wbuf_q == BUF_W'(tbuf_q + 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_REC;
      wbuf_q   <= '0;
      tbuf_q   <= '0;
      pcnt_q   <= '0;
      rcnt_q   <= '0;
      primed_q <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      if (trig_take) begin
        busy_q <= 1'b1;
        tbuf_q <= wbuf_q;
      end
      case (mode_q)
        MODE_REC: begin
          if (frame_end) begin
            pcnt_q   <= '0;
            wbuf_q   <= BUF_W'(wbuf_q + 1'b1);
            primed_q <= 1'b1;
            if (next_done) mode_q <= MODE_READ;
          end else if (wr_en) begin
            pcnt_q <= ADDR_W'(pcnt_q + 1'b1);
          end
        end
        MODE_READ: begin
          if (rd_done) begin
            busy_q   <= 1'b0;
            primed_q <= 1'b0;
            rcnt_q   <= '0;
            mode_q   <= MODE_RST;
          end
        end
        MODE_RST: begin
          if (rcnt_q == RCNT_W'(RST_CYCLES - 1)) begin
            mode_q <= MODE_REC;
            pcnt_q <= '0;
          end else begin
            rcnt_q <= RCNT_W'(rcnt_q + 1'b1);
          end
        end
        default: mode_q <= MODE_REC;
      endcase
    end
  end

  assign wr_buf   = wbuf_q;
  assign wr_addr  = pcnt_q;
  assign busy     = busy_q;
  assign sens_rst = (mode_q == MODE_RST);
  assign reading  = (mode_q == MODE_READ);
  assign trig_buf = tbuf_q;

  // R5: a taken trigger raises busy on the next edge
  a_r5_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    trig_take |=> busy_q);

  // R4: the selected trigger frame cannot move while busy
  a_r4_tbuf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(tbuf_q));

  // R6: readout only begins right after a frame closed
  a_r6_freeze_on_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_READ) && $past(mode_q == MODE_REC)) |-> $past(frame_end));

  // R10: no recording and no pending event during sensor reset
  a_r10_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RST) |-> (!busy_q && !wr_en));
endmodule

// File: rtl/mfc_reader.sv
module mfc_reader #(
  parameter int NBUF   = 4,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reading,
  input  logic [$clog2(NBUF)-1:0]  trig_buf,
  input  logic                     rd_ready,
  output logic                     rd_valid,
  output logic [$clog2(NBUF)-1:0]  rd_buf,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic [1:0]               rd_frame,
  output logic                     rd_last,
  output logic                     rd_done
);
  localparam int BUF_W = $clog2(NBUF);

  logic [1:0]        fidx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              hs, frame_tail;

  assign rd_valid   = reading;
  assign hs         = rd_valid && rd_ready;
  assign frame_tail = (addr_q == '1);
  assign rd_last    = rd_valid && frame_tail && (fidx_q == 2'd2);
  assign rd_done    = hs && rd_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fidx_q <= '0;
      addr_q <= '0;
    end else if (hs) begin
      addr_q <= ADDR_W'(addr_q + 1'b1);
      if (frame_tail) fidx_q <= (fidx_q == 2'd2) ? 2'd0 : 2'(fidx_q + 1'b1);
    end
  end

  // slot order: previous, trigger, next
  assign rd_buf   = BUF_W'(trig_buf + BUF_W'(fidx_q) - BUF_W'(1));
  assign rd_addr  = addr_q;
  assign rd_frame = fidx_q;

  // R8: stalled read outputs stay put
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_frame)));

  // R7: addresses step by one within a frame
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !frame_tail) |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));
endmodule

// File: rtl/mfc_capture.sv
module mfc_capture #(
  parameter int PIX_W      = 8,
  parameter int NBUF       = 4,
  parameter int ADDR_W     = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              trig,
  output logic              busy,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [PIX_W-1:0]  rd_data,
  output logic [1:0]        rd_frame,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_last,
  output logic              sens_rst
);
  localparam int BUF_W = $clog2(NBUF);

  logic              wr_en, reading, rd_done;
  logic [BUF_W-1:0]  wr_buf, trig_buf, rd_buf;
  logic [ADDR_W-1:0] wr_addr;

  mfc_ctrl #(.NBUF(NBUF), .ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .trig(trig),
    .rd_done(rd_done), .pix_ready(pix_ready), .wr_en(wr_en),
    .wr_buf(wr_buf), .wr_addr(wr_addr), .busy(busy), .sens_rst(sens_rst),
    .reading(reading), .trig_buf(trig_buf)
  );

  mfc_store #(.PIX_W(PIX_W), .NBUF(NBUF), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr),
    .wr_data(pix_data), .rd_buf(rd_buf), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  mfc_reader #(.NBUF(NBUF), .ADDR_W(ADDR_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .reading(reading), .trig_buf(trig_buf),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_buf(rd_buf),
    .rd_addr(rd_addr), .rd_frame(rd_frame), .rd_last(rd_last),
    .rd_done(rd_done)
  );

  // R2: the input is never accepted while the read port is active
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_ready && rd_valid));
endmodule

// File: tb/tb_mfc_capture.sv
module tb_mfc_capture;
  localparam int PIX_W = 8, ADDR_W = 4, FRAME_PIX = 16, RST_CYCLES = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 1'b0, trig = 1'b0, rd_ready = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic pix_ready, busy, rd_valid, rd_last, sens_rst;
  logic [PIX_W-1:0] rd_data;
  logic [1:0] rd_frame;
  logic [ADDR_W-1:0] rd_addr;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  mfc_capture #(.PIX_W(PIX_W), .NBUF(4), .ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .trig(trig), .busy(busy), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_frame(rd_frame),
    .rd_addr(rd_addr), .rd_last(rd_last), .sens_rst(sens_rst)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // vector: {F[3:0], P[3:0], gap, stall, early, extra}
  localparam logic [11:0] VEC [0:5] = '{
    {4'd1, 4'd0,  1'b0, 1'b0, 1'b1, 1'b0},
    {4'd2, 4'd15, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd3, 4'd7,  1'b0, 1'b1, 1'b1, 1'b1},
    {4'd5, 4'd9,  1'b1, 1'b0, 1'b0, 1'b0},
    {4'd1, 4'd15, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd4, 4'd3,  1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic run_event(int f, int p, bit gap, bit stall, bit early, bit extra);
    int g = 0, a = 0, cyc = 0, lat = 0, n = 0;
    bit sent = 0, counting = 0, ready_bad = 0, chk_busy = 0, chk_idle = 0, tog = 0;
    while (!(g == f + 2)) begin
      @(negedge clk);
      if (chk_busy) begin check("R5 busy after trigger", 32'(busy), 1); chk_busy = 0; end
      if (chk_idle) begin check("R4 unprimed trigger ignored", 32'(busy), 0); chk_idle = 0; end
      if (pix_ready !== 1'b1) ready_bad = 1;
      pix_valid = !(gap && (cyc % 3 == 2));
      cyc++;
      pix_data = 8'((g % 16) * 16 + a);
      trig = pix_valid && ((g == f && a == P_of(p) && !sent) ||
                           (early && g == 0 && a == 5) ||
                           (extra && g == f + 1 && a == 3));
      @(posedge clk);
      if (pix_valid) begin
        if (trig && g == f && !sent) begin sent = 1; counting = 1; chk_busy = 1; end
        if (trig && g == 0) chk_idle = 1;
        if (counting) lat++;
        a++;
        if (a == FRAME_PIX) begin a = 0; g++; end
      end
    end
    @(negedge clk);
    pix_valid = 0; trig = 0;
    check("R2 ready while recording", 32'(ready_bad), 0);
    check("R6 ready low after next frame", 32'(pix_ready), 0);
    check("R6 pixels from trigger to freeze", 32'(lat), 32'(2 * FRAME_PIX - p));
    check("R5 busy held until readout", 32'(busy), 1);
    // readout
    for (int k = 0; k < 3; k++) begin
      for (int ad = 0; ad < FRAME_PIX; ad++) begin
        bit done = 0;
        logic [7:0] exp = 8'(((f - 1 + k) % 16) * 16 + ad);
        while (!done) begin
          @(negedge clk);
          if (k > 0 || ad > 0) trig = extra;
          rd_ready = !(stall && tog);
          tog = !tog;
          if (rd_ready) begin
            check("R7 valid", 32'(rd_valid), 1);
            check("R9 raw data", 32'(rd_data), 32'(exp));
            check("R7 frame tag", 32'(rd_frame), 32'(k));
            check("R7 address", 32'(rd_addr), 32'(ad));
            check("R7 last flag", 32'(rd_last), 32'(k == 2 && ad == FRAME_PIX - 1));
          end else begin
            check("R8 held while stalled", 32'({rd_valid, rd_data}), 32'({1'b1, exp}));
          end
          @(posedge clk);
          if (rd_ready) done = 1;
        end
      end
    end
    @(negedge clk);
    rd_ready = 0;
    check("R5 busy low after last read", 32'(busy), 0);
    check("R10 sensor reset starts", 32'(sens_rst), 1);
    while (sens_rst === 1'b1 && n < 100) begin n++; @(negedge clk); end
    check("R10 reset length", 32'(n), RST_CYCLES);
    check("R10 recording resumes", 32'(pix_ready), 1);
    trig = 0;
    @(negedge clk);
    check("R4 trigger during readout/reset ignored", 32'(busy), 0);
  endtask

  function automatic int P_of(int p); return p; endfunction

  initial begin : watchdog
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    n_bad++;
    $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy at reset", 32'(busy), 0);
    check("R1 rd_valid at reset", 32'(rd_valid), 0);
    check("R1 sens_rst at reset", 32'(sens_rst), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pix_ready after reset", 32'(pix_ready), 1);
    // R3: each vector places the trigger at frame F, pixel P
    for (int v = 0; v < 6; v++) begin
      run_event(int'(VEC[v][11:8]), int'(VEC[v][7:4]), VEC[v][3], VEC[v][2],
                VEC[v][1], VEC[v][0]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule